// File: doc/BRIEF.md
# Prioritized Interrupt Vector Arbiter

This block keeps a set of 32 pending interrupt requests and, on every clock, chooses at most one of them to service. Each source gets a two-bit priority level. The five lowest sources are fixed at the top level. Source 7 is reserved and can never be taken. Every other source reads an enable bit and a level from one of seven peripheral priority fields. A pending request is eligible only when its source is enabled and its level is at least the two-bit mask taken from the processor status. Among the eligible requests, the highest level wins, and a tie goes to the lower source index.

When a request is taken, the block pulses a take strobe for one cycle and outputs the vector address for the program counter. The pending bit of that source is cleared. For most sources the vector is twice the source index. The host command source (22) instead uses a host vector supplied at run time, shifted left by one, and taking it also pulses a host-command clear strobe. Requests that are not eligible stay pending until the mask or the fields allow them.

Top module: `irq_vector_arbiter`

## Requirements
- R1: While reset is held and in the first cycle after it, `takeStrobe` and `hostCmdClr` are 0, `takeVector` is 0 and nothing is pending.
- R2: A 1 on `reqSet[n]` at a clock edge makes source n pending. A pending request that is not taken stays pending across changes of mask and fields. Taking source n clears only bit n. A new request for n at the same edge as its take leaves it pending.
- R3: Sources 0 to 4 always have level 3 and are always enabled, whatever the mask and the fields are.
- R4: Source 7 is never taken, even when it is pending.
- R5: `prioFields` holds seven 3-bit fields. Field k sits at bits [3k+2:3k], with bit 3k+2 as the enable and [3k+1:3k] as the level. Field 0 serves source 5, field 1 source 6, field 2 sources 8–11, field 3 sources 12–15, field 4 sources 16–17, field 5 sources 18–22 and 24–31, and field 6 source 23.
- R6: A field whose enable bit is 0 blocks all of its sources from being taken.
- R7: An enabled pending source is eligible only if its level is greater than or equal to `intMask`.
- R8: The eligible source with the highest level is taken. Between equal levels, the lower source index wins.
- R9: For every source except 22, the vector is 2·n (0x0000 to 0x003E).
- R10: For source 22 the vector is `{hostVec,1'b0}`, and `hostCmdClr` pulses in the same cycle as `takeStrobe`. It never pulses for any other source.
- R11: At most one request is taken per cycle. `takeStrobe` rises in the cycle after the edge that saw the request pending. Several pending requests are served on consecutive cycles in priority order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqSet | input | 32 | One bit per source; sets that source pending |
| intMask | input | 2 | Minimum level a request needs to be taken |
| prioFields | input | 21 | Seven enable+level fields for the peripheral sources |
| hostVec | input | 5 | Run-time vector field for the host command source |
| takeStrobe | output | 1 | One-cycle pulse when a request is taken |
| takeVector | output | 16 | Vector of the last taken request |
| hostCmdClr | output | 1 | Pulse that clears the host command when source 22 is taken |

## Verification
The assertions check several properties on every cycle. A chosen winner is always pending and never the reserved source. It always meets the mask. A pending fixed source always wins. A take clears exactly the winner's pending bit unless the same bit is set again. The host clear never occurs without a take, and taken vectors are even. Only the bench's scenarios can show the following: the mapping from each source to its field, the vector values themselves, the ordering across levels and ties, the release of a held request when the mask drops, and the consecutive-cycle draining of several requests.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int NUM_SRC    = 32;
  localparam int IDX_W      = $clog2(NUM_SRC);
  localparam int NUM_FIELDS = 7;
  localparam int FIELD_W    = 3;
  localparam int NUM_FIXED  = 5;
  localparam int RSVD_SRC   = 7;
  localparam int HOST_SRC   = 22;

  // Field slots inside the priority input
  typedef enum int {
    FLD_EXTA  = 0,
    FLD_EXTB  = 1,
    FLD_SER0  = 2,
    FLD_SER1  = 3,
    FLD_TMR   = 4,
    FLD_HOST  = 5,
    FLD_CODEC = 6
  } fieldSlot_e;

  // Control-to-datapath strobes
  typedef struct packed {
    logic             take;
    logic [IDX_W-1:0] idx;
    logic             hostCmd;
  } arbStrobe_t;

  function automatic int srcField(input int s);
    if (s == 5)                 return FLD_EXTA;
    else if (s == 6)            return FLD_EXTB;
    else if (s >= 8 && s <= 11) return FLD_SER0;
    else if (s >= 12 && s <= 15) return FLD_SER1;
    else if (s == 16 || s == 17) return FLD_TMR;
    else if (s == 23)           return FLD_CODEC;
    else                        return FLD_HOST;
  endfunction
endpackage

// File: rtl/irq_arb_ctrl.sv
module irq_arb_ctrl
  import irq_arb_pkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_SRC-1:0]            pending,
  input  logic [1:0]                    intMask,
  input  logic [NUM_FIELDS*FIELD_W-1:0] prioFields,
  output arbStrobe_t                    strb
);
  logic [NUM_SRC-1:0] srcEn;
  logic [1:0]         srcLvl [NUM_SRC];
  logic [NUM_SRC-1:0] elig;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    if (s < NUM_FIXED) begin : g_fixed
      assign srcEn[s]  = 1'b1;
      assign srcLvl[s] = 2'd3;
    end else if (s == RSVD_SRC) begin : g_rsvd
      assign srcEn[s]  = 1'b0;
      assign srcLvl[s] = 2'd0;
    end else begin : g_field
      localparam int F = srcField(s);
      assign srcEn[s]  = prioFields[F*FIELD_W + 2];
      assign srcLvl[s] = prioFields[F*FIELD_W +: 2];
    end
    assign elig[s] = pending[s] & srcEn[s] & (srcLvl[s] >= intMask);
  end

  // Highest level first, lowest index inside a level
  always_comb begin
    strb = '0;
    for (int l = 3; l >= 0; l--) begin
      for (int s = 0; s < NUM_SRC; s++) begin
        if (!strb.take && elig[s] && srcLvl[s] == 2'(l)) begin
          strb.take    = 1'b1;
          strb.idx     = IDX_W'(s);
          strb.hostCmd = (s == HOST_SRC);
        end
      end
    end
  end

  assert_winner_pending_R11: assert property (@(posedge clk) disable iff (!rstN)
    strb.take |-> pending[strb.idx]);
  assert_reserved_never_R4: assert property (@(posedge clk) disable iff (!rstN)
    strb.take |-> strb.idx != IDX_W'(RSVD_SRC));
  assert_meets_mask_R7: assert property (@(posedge clk) disable iff (!rstN)
    strb.take |-> srcLvl[strb.idx] >= intMask);
  assert_fixed_wins_R3: assert property (@(posedge clk) disable iff (!rstN)
    (|pending[NUM_FIXED-1:0]) |-> (strb.take && strb.idx < IDX_W'(NUM_FIXED)));
endmodule

// File: rtl/irq_arb_dpath.sv
module irq_arb_dpath
  import irq_arb_pkg::*;
#(
  parameter int VEC_W = 16,
  parameter int HV_W  = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] reqSet,
  input  logic [HV_W-1:0]    hostVec,
  input  arbStrobe_t         strb,
  output logic [NUM_SRC-1:0] pending,
  output logic               takeOut,
  output logic [VEC_W-1:0]   vecOut,
  output logic               hcClrOut
);
  logic [NUM_SRC-1:0] clrMask;
  logic [VEC_W-1:0]   nextVec;

  assign clrMask = NUM_SRC'(strb.take) << strb.idx;
  assign nextVec = strb.hostCmd ? VEC_W'({hostVec, 1'b0}) : VEC_W'({strb.idx, 1'b0});

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending  <= '0;
      takeOut  <= 1'b0;
      vecOut   <= '0;
      hcClrOut <= 1'b0;
    end else begin
      pending  <= (pending & ~clrMask) | reqSet;
      takeOut  <= strb.take;
      hcClrOut <= strb.take & strb.hostCmd;
      if (strb.take) vecOut <= nextVec;
    end
  end

  assert_take_clears_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.take |=> pending[$past(strb.idx)] == $past(reqSet[strb.idx]));
  assert_hc_with_take_R10: assert property (@(posedge clk) disable iff (!rstN)
    hcClrOut |-> takeOut);
  assert_even_vector_R9: assert property (@(posedge clk) disable iff (!rstN)
    takeOut |-> !vecOut[0]);
endmodule

// File: rtl/irq_vector_arbiter.sv
module irq_vector_arbiter
  import irq_arb_pkg::*;
#(
  parameter int VEC_W = 16,
  parameter int HV_W  = 5
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_SRC-1:0]            reqSet,
  input  logic [1:0]                    intMask,
  input  logic [NUM_FIELDS*FIELD_W-1:0] prioFields,
  input  logic [HV_W-1:0]               hostVec,
  output logic                          takeStrobe,
  output logic [VEC_W-1:0]              takeVector,
  output logic                          hostCmdClr
);
  arbStrobe_t         strb;
  logic [NUM_SRC-1:0] pending;

  irq_arb_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .pending    (pending),
    .intMask    (intMask),
    .prioFields (prioFields),
    .strb       (strb)
  );

  irq_arb_dpath #(.VEC_W(VEC_W), .HV_W(HV_W)) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .reqSet   (reqSet),
    .hostVec  (hostVec),
    .strb     (strb),
    .pending  (pending),
    .takeOut  (takeStrobe),
    .vecOut   (takeVector),
    .hcClrOut (hostCmdClr)
  );
endmodule

// File: tb/irq_vector_arbiter_bench.sv
module irq_vector_arbiter_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] reqSet = '0;
  logic [1:0]  intMask = '0;
  logic [20:0] prioFields = '0;
  logic [4:0]  hostVec = '0;
  logic        takeStrobe;
  logic [15:0] takeVector;
  logic        hostCmdClr;

  int nChecks = 0;
  int nFail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_vector_arbiter u_irq_vector_arbiter (
    .clk(clk), .rstN(rstN), .reqSet(reqSet), .intMask(intMask),
    .prioFields(prioFields), .hostVec(hostVec),
    .takeStrobe(takeStrobe), .takeVector(takeVector), .hostCmdClr(hostCmdClr)
  );

  typedef struct packed {
    logic [31:0] req;
    logic [1:0]  mask;
    logic [20:0] fld;
    logic [4:0]  hv;
    logic        expTake;
    logic [15:0] expVec;
    logic        expHc;
    logic [7:0]  tag;
  } vec_t;

  // Fields are octal digits: digit k = field k, value 4+level when enabled
  localparam vec_t TBL [17] = '{
    '{32'h0000_0001, 2'd3, 21'o0000000, 5'h00, 1'b1, 16'h0000, 1'b0, 8'd3},  // R3
    '{32'h0000_0010, 2'd3, 21'o0000000, 5'h00, 1'b1, 16'h0008, 1'b0, 8'd3},  // R3
    '{32'h0000_0020, 2'd3, 21'o0000007, 5'h00, 1'b1, 16'h000A, 1'b0, 8'd5},  // R5
    '{32'h0000_0040, 2'd1, 21'o0000050, 5'h00, 1'b1, 16'h000C, 1'b0, 8'd5},  // R5
    '{32'h0000_0040, 2'd2, 21'o0000050, 5'h00, 1'b0, 16'h0000, 1'b0, 8'd7},  // R7
    '{32'h0000_0200, 2'd2, 21'o0000600, 5'h00, 1'b1, 16'h0012, 1'b0, 8'd5},  // R5
    '{32'h0000_2000, 2'd0, 21'o0004000, 5'h00, 1'b1, 16'h001A, 1'b0, 8'd5},  // R5
    '{32'h0002_0000, 2'd3, 21'o0070000, 5'h00, 1'b1, 16'h0022, 1'b0, 8'd5},  // R5
    '{32'h0010_0000, 2'd1, 21'o0600000, 5'h00, 1'b1, 16'h0028, 1'b0, 8'd5},  // R5
    '{32'h0080_0000, 2'd0, 21'o5000000, 5'h00, 1'b1, 16'h002E, 1'b0, 8'd5},  // R5
    '{32'h0080_0000, 2'd0, 21'o3000000, 5'h00, 1'b0, 16'h0000, 1'b0, 8'd6},  // R6
    '{32'h0040_0000, 2'd0, 21'o0700000, 5'h13, 1'b1, 16'h0026, 1'b1, 8'd10}, // R10
    '{32'h8000_0000, 2'd0, 21'o0400000, 5'h00, 1'b1, 16'h003E, 1'b0, 8'd9},  // R9
    '{32'h0002_0200, 2'd0, 21'o0060500, 5'h00, 1'b1, 16'h0022, 1'b0, 8'd8},  // R8 level
    '{32'h0000_3000, 2'd0, 21'o0006000, 5'h00, 1'b1, 16'h0018, 1'b0, 8'd8},  // R8 tie
    '{32'h0000_0080, 2'd0, 21'o7777777, 5'h00, 1'b0, 16'h0000, 1'b0, 8'd4},  // R4
    '{32'h0000_0021, 2'd0, 21'o0000007, 5'h00, 1'b1, 16'h0000, 1'b0, 8'd8}   // R8 tie at 3
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    reqSet = '0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  // Pulse at a negedge; the take appears two negedges later
  task automatic pulseReq(input logic [31:0] bits);
    reqSet = bits;
    @(negedge clk);
    reqSet = '0;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nFail++;
    nChecks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    // R1 reset state
    rstN = 1'b0;
    reqSet = 32'hFFFF_FFFF;
    repeat (2) @(negedge clk);
    chk("R1 take in reset", 32'(takeStrobe), 0);
    chk("R1 vector in reset", 32'(takeVector), 0);
    chk("R1 hc in reset", 32'(hostCmdClr), 0);
    reqSet = '0;
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 nothing pending after reset", 32'(takeStrobe), 0);

    // Table walk
    for (int i = 0; i < 17; i++) begin
      doReset();
      intMask = TBL[i].mask;
      prioFields = TBL[i].fld;
      hostVec = TBL[i].hv;
      pulseReq(TBL[i].req);
      chk($sformatf("R%0d row %0d take", TBL[i].tag, i), 32'(takeStrobe), 32'(TBL[i].expTake));
      if (TBL[i].expTake)
        chk($sformatf("R%0d row %0d vector", TBL[i].tag, i), 32'(takeVector), 32'(TBL[i].expVec));
      chk($sformatf("R%0d row %0d host clear", TBL[i].tag, i), 32'(hostCmdClr), 32'(TBL[i].expHc));
    end

    // R11: drain three requests on consecutive cycles in priority order
    doReset();
    intMask = 2'd0;
    prioFields = 21'o0060500;
    pulseReq(32'h0002_0204);
    chk("R11 first take", 32'(takeStrobe), 1);
    chk("R11 first vector", 32'(takeVector), 32'h04);
    @(negedge clk);
    chk("R11 second take", 32'(takeStrobe), 1);
    chk("R11 second vector", 32'(takeVector), 32'h22);
    @(negedge clk);
    chk("R11 third take", 32'(takeStrobe), 1);
    chk("R11 third vector", 32'(takeVector), 32'h12);
    @(negedge clk);
    chk("R11 drained", 32'(takeStrobe), 0);
    chk("R11 vector held", 32'(takeVector), 32'h12);

    // R2/R7: held request released when the mask drops
    doReset();
    intMask = 2'd2;
    prioFields = 21'o0000005;
    pulseReq(32'h0000_0020);
    chk("R7 blocked by mask", 32'(takeStrobe), 0);
    @(negedge clk);
    chk("R2 still held", 32'(takeStrobe), 0);
    intMask = 2'd1;
    @(negedge clk);
    chk("R2 released take", 32'(takeStrobe), 1);
    chk("R2 released vector", 32'(takeVector), 32'h0A);
    @(negedge clk);
    chk("R2 cleared after take", 32'(takeStrobe), 0);

    // R2: re-request at the same edge as the take keeps it pending
    doReset();
    intMask = 2'd0;
    prioFields = 21'o0070000;
    reqSet = 32'h0002_0000;
    @(negedge clk);
    @(negedge clk);
    chk("R2 first take", 32'(takeStrobe), 1);
    reqSet = '0;
    @(negedge clk);
    chk("R2 retaken", 32'(takeStrobe), 1);
    chk("R2 retaken vector", 32'(takeVector), 32'h22);
    @(negedge clk);
    chk("R2 gone", 32'(takeStrobe), 0);

    // R10: host source at a lower level than a peripheral, hc only with 22
    doReset();
    intMask = 2'd0;
    hostVec = 5'h1F;
    prioFields = 21'o0570000;
    pulseReq(32'h0042_0000);
    chk("R10 timer first", 32'(takeVector), 32'h22);
    chk("R10 no hc for timer", 32'(hostCmdClr), 0);
    @(negedge clk);
    chk("R10 host vector", 32'(takeVector), 32'h3E);
    chk("R10 hc pulse", 32'(hostCmdClr), 1);
    @(negedge clk);
    chk("R10 hc single cycle", 32'(hostCmdClr), 0);

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule